// File: doc/BRIEF.md
# Two-Dimensional Strided Address Generator

This block walks a rectangular block transfer row by row. A single load strobe captures a request: an identifier, source and destination base addresses, an independent stride for each side, a row length and a row count. The row length and the row count are both held as "value minus one". The block then presents the start address and the byte count of the current row to a data mover. It also presents a running current address on each side. That address advances by the bus width for every data beat the mover reports. When the mover signals that a row is complete, the block moves both sides on to the next row.

At the end of the last row the block pulses a completion output. That output carries the request identifier and the total byte count (x+1)*(y+1). If the cyclic flag is set, the block restarts at the first row on its own. An abort input stops the request early. The block then pulses a partial output carrying the identifier and the number of bytes moved so far.

The stored row length saturates at the largest supported value and has its alignment bits forced to ones. Software can therefore load all-ones to learn the maximum row length, or zero to learn the alignment mask. When the two-dimensional option is disabled, the row count always reads back zero.

Top module: `strided_agen`

## Requirements
- R1: The stored row length `x_len_o` equals min(`load_x_i`, 2^LEN_W-1) with its low log2(BUS_BYTES) bits forced to 1. `row_bytes_o` is `x_len_o`+1. With the defaults (LEN_W=8, BUS_BYTES=4), loading 0xFFFF reads back 255 and loading 0 reads back 3.
- R2: `y_len_o` holds the loaded row count minus one. When TWO_D=0 it reads back 0 whatever was loaded.
- R3: While row r is current, `row_src_o` is src_base + r*src_stride and `row_dst_o` is dst_base + r*dst_stride, with each side using its own stride. `row_idx_o` equals r.
- R4: Each `beat_i` in a busy cycle without `row_done_i` or `abort_i` advances `cur_src_o` and `cur_dst_o` by BUS_BYTES. A `row_done_i` sets both current addresses to the next row's start.
- R5: A `row_done_i` on the last row pulses `done_o` for one cycle, with `rpt_id_o` set to the request identifier and `rpt_len_o` set to (x+1)*(y+1). In non-cyclic mode `busy_o` falls in the same cycle.
- R6: In cyclic mode the last row's `row_done_i` also pulses `done_o`, but `busy_o` stays high. Row index, row addresses and current addresses all return to row 0.
- R7: An `abort_i` while busy drops `busy_o` and pulses `partial_o`. `rpt_len_o` is then the bytes of all completed rows plus BUS_BYTES times the beats seen in the current row, counting a beat in the abort cycle. A `row_done_i` in the same cycle counts the whole current row.
- R8: When `abort_i` coincides with the last row's `row_done_i`, the request is reported through `done_o` with the full length, and `partial_o` stays low.
- R9: A `load_i` while busy is ignored. While idle, `beat_i`, `row_done_i` and `abort_i` have no effect on the outputs.
- R10: After reset `busy_o`, `done_o` and `partial_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Capture request fields and start (only when idle) |
| load_id_i | input | IDW | Request identifier |
| load_src_i | input | AW | Source base address |
| load_dst_i | input | AW | Destination base address |
| load_src_stride_i | input | AW | Source row stride in bytes |
| load_dst_stride_i | input | AW | Destination row stride in bytes |
| load_x_i | input | XIN_W | Bytes per row minus one |
| load_y_i | input | YW | Rows minus one |
| load_cyclic_i | input | 1 | Restart automatically after the last row |
| beat_i | input | 1 | One bus-width beat moved in the current row |
| row_done_i | input | 1 | Current row complete |
| abort_i | input | 1 | Stop the request early |
| busy_o | output | 1 | Request in progress |
| row_idx_o | output | YW | Current row index |
| row_bytes_o | output | LEN_W+1 | Bytes in each row |
| row_src_o | output | AW | Source start address of current row |
| row_dst_o | output | AW | Destination start address of current row |
| cur_src_o | output | AW | Current source address |
| cur_dst_o | output | AW | Current destination address |
| x_len_o | output | LEN_W | Stored (clamped) row length minus one |
| y_len_o | output | YW | Stored row count minus one |
| done_o | output | 1 | One-cycle pulse: request or cyclic pass complete |
| partial_o | output | 1 | One-cycle pulse: request stopped early |
| rpt_id_o | output | IDW | Identifier of the reported request |
| rpt_len_o | output | LEN_W+YW+1 | Bytes reported with done or partial |

## Verification
Two functions can land on the same cycle: completion of a row and an early stop. The bench provokes this by raising `abort_i` together with `row_done_i`, both on a middle row and on the last row. It also repeats the middle-row case inside a cyclic pass. On a middle row the result must be a partial report that includes the whole row. On the last row it must be a completion with the full length and no partial pulse. A beat arriving in the abort cycle is checked for inclusion in the partial length as well.

// File: rtl/strided_agen.sv
module strided_agen #(
  parameter int AW        = 16,
  parameter int IDW       = 4,
  parameter int XIN_W     = 16,
  parameter int LEN_W     = 8,
  parameter int YW        = 4,
  parameter int BUS_BYTES = 4,
  parameter bit TWO_D     = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic [IDW-1:0]         load_id_i,
  input  logic [AW-1:0]          load_src_i,
  input  logic [AW-1:0]          load_dst_i,
  input  logic [AW-1:0]          load_src_stride_i,
  input  logic [AW-1:0]          load_dst_stride_i,
  input  logic [XIN_W-1:0]       load_x_i,
  input  logic [YW-1:0]          load_y_i,
  input  logic                   load_cyclic_i,
  input  logic                   beat_i,
  input  logic                   row_done_i,
  input  logic                   abort_i,
  output logic                   busy_o,
  output logic [YW-1:0]          row_idx_o,
  output logic [LEN_W:0]         row_bytes_o,
  output logic [AW-1:0]          row_src_o,
  output logic [AW-1:0]          row_dst_o,
  output logic [AW-1:0]          cur_src_o,
  output logic [AW-1:0]          cur_dst_o,
  output logic [LEN_W-1:0]       x_len_o,
  output logic [YW-1:0]          y_len_o,
  output logic                   done_o,
  output logic                   partial_o,
  output logic [IDW-1:0]         rpt_id_o,
  output logic [LEN_W+YW:0]      rpt_len_o
);
  localparam int AB = $clog2(BUS_BYTES);
  localparam int TW = LEN_W + YW + 1;
  localparam logic [XIN_W-1:0] XMAX = XIN_W'((1 << LEN_W) - 1);
  localparam logic [LEN_W-1:0] AMASK = LEN_W'(BUS_BYTES - 1);

  logic           busy_q, cyc_q, done_q, part_q;
  logic [IDW-1:0] id_q, rid_q;
  logic [AW-1:0]  sbase_q, dbase_q, ss_q, ds_q, rsrc_q, rdst_q, csrc_q, cdst_q;
  logic [LEN_W-1:0] x_q, beats_q;
  logic [YW-1:0]  y_q, ridx_q;
  logic [TW-1:0]  moved_q, rlen_q;

  logic [LEN_W-1:0] x_clamp;
  logic [YW-1:0]    y_clamp;
  logic [LEN_W:0]   rbytes;
  logic [TW-1:0]    total, beat_bytes;
  logic             last_row;

  assign x_clamp    = ((load_x_i > XMAX) ? XMAX[LEN_W-1:0] : load_x_i[LEN_W-1:0]) | AMASK;
  assign y_clamp    = TWO_D ? load_y_i : '0;
  assign rbytes     = {1'b0, x_q} + 1'b1;
  assign total      = TW'(rbytes) * (TW'(y_q) + 1'b1);
  assign beat_bytes = (TW'(beats_q) + TW'(beat_i)) << AB;
  assign last_row   = (ridx_q == y_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; cyc_q <= 1'b0; done_q <= 1'b0; part_q <= 1'b0;
      id_q <= '0; rid_q <= '0; sbase_q <= '0; dbase_q <= '0;
      ss_q <= '0; ds_q <= '0; rsrc_q <= '0; rdst_q <= '0;
      csrc_q <= '0; cdst_q <= '0; x_q <= '0; beats_q <= '0;
      y_q <= '0; ridx_q <= '0; moved_q <= '0; rlen_q <= '0;
    end else begin
      done_q <= 1'b0;
      part_q <= 1'b0;
      if (!busy_q) begin
        if (load_i) begin
          busy_q  <= 1'b1;
          cyc_q   <= load_cyclic_i;
          id_q    <= load_id_i;
          sbase_q <= load_src_i;  dbase_q <= load_dst_i;
          rsrc_q  <= load_src_i;  rdst_q  <= load_dst_i;
          csrc_q  <= load_src_i;  cdst_q  <= load_dst_i;
          ss_q    <= load_src_stride_i;
          ds_q    <= load_dst_stride_i;
          x_q     <= x_clamp;
          y_q     <= y_clamp;
          ridx_q  <= '0;
          beats_q <= '0;
          moved_q <= '0;
        end
      end else if (row_done_i) begin
        beats_q <= '0;
        if (last_row) begin
          done_q <= 1'b1;
          rid_q  <= id_q;
          rlen_q <= total;
          if (cyc_q && !abort_i) begin
            ridx_q <= '0;
            rsrc_q <= sbase_q; rdst_q <= dbase_q;
            csrc_q <= sbase_q; cdst_q <= dbase_q;
            moved_q <= '0;
          end else begin
            busy_q <= 1'b0;
          end
        end else begin
          ridx_q  <= ridx_q + 1'b1;
          rsrc_q  <= rsrc_q + ss_q;  csrc_q <= rsrc_q + ss_q;
          rdst_q  <= rdst_q + ds_q;  cdst_q <= rdst_q + ds_q;
          moved_q <= moved_q + TW'(rbytes);
          if (abort_i) begin
            busy_q <= 1'b0;
            part_q <= 1'b1;
            rid_q  <= id_q;
            rlen_q <= moved_q + TW'(rbytes);
          end
        end
      end else if (abort_i) begin
        busy_q <= 1'b0;
        part_q <= 1'b1;
        rid_q  <= id_q;
        rlen_q <= moved_q + beat_bytes;
      end else if (beat_i) begin
        csrc_q  <= csrc_q + AW'(BUS_BYTES);
        cdst_q  <= cdst_q + AW'(BUS_BYTES);
        beats_q <= beats_q + 1'b1;
      end
    end
  end

  assign busy_o      = busy_q;
  assign row_idx_o   = ridx_q;
  assign row_bytes_o = rbytes;
  assign row_src_o   = rsrc_q;
  assign row_dst_o   = rdst_q;
  assign cur_src_o   = csrc_q;
  assign cur_dst_o   = cdst_q;
  assign x_len_o     = x_q;
  assign y_len_o     = y_q;
  assign done_o      = done_q;
  assign partial_o   = part_q;
  assign rpt_id_o    = rid_q;
  assign rpt_len_o   = rlen_q;
endmodule

// File: rtl/strided_agen_chk.sv
module strided_agen_chk #(
  parameter int AW        = 16,
  parameter int LEN_W     = 8,
  parameter int BUS_BYTES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_i,
  input logic             beat_i,
  input logic             row_done_i,
  input logic             abort_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             partial_o,
  input logic             cyc_q,
  input logic [AW-1:0]    cur_src_o,
  input logic [AW-1:0]    cur_dst_o,
  input logic [LEN_W-1:0] x_len_o
);
  localparam int AB = $clog2(BUS_BYTES);

  assert_align_forced_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (&x_len_o[AB-1:0]));

  assert_beat_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && beat_i && !row_done_i && !abort_i) |=>
      (cur_src_o == $past(cur_src_o) + AW'(BUS_BYTES)) && (cur_dst_o == $past(cur_dst_o) + AW'(BUS_BYTES)));

  assert_done_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !cyc_q) |-> !busy_o);

  assert_cyclic_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cyc_q && row_done_i && !abort_i) |=> busy_o);

  assert_partial_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    partial_o |-> !busy_o);

  assert_done_partial_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && partial_o));

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !load_i) |=> ($stable(cur_src_o) && !busy_o && !done_o && !partial_o));
endmodule

bind strided_agen strided_agen_chk #(.AW(AW), .LEN_W(LEN_W), .BUS_BYTES(BUS_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .beat_i(beat_i),
  .row_done_i(row_done_i), .abort_i(abort_i), .busy_o(busy_o),
  .done_o(done_o), .partial_o(partial_o), .cyc_q(cyc_q),
  .cur_src_o(cur_src_o), .cur_dst_o(cur_dst_o), .x_len_o(x_len_o)
);

// File: tb/strided_agen_tb.sv
`timescale 1ns/1ps
module strided_agen_tb;
  localparam int AW = 16, IDW = 4, XIN_W = 16, LEN_W = 8, YW = 4, BB = 4;
  localparam int TW = LEN_W + YW + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic load_i = 0, load_cyclic_i = 0, beat_i = 0, row_done_i = 0, abort_i = 0;
  logic [IDW-1:0] load_id_i = '0;
  logic [AW-1:0] load_src_i = '0, load_dst_i = '0, load_src_stride_i = '0, load_dst_stride_i = '0;
  logic [XIN_W-1:0] load_x_i = '0;
  logic [YW-1:0] load_y_i = '0;

  logic busy_o, done_o, partial_o;
  logic [YW-1:0] row_idx_o, y_len_o;
  logic [LEN_W:0] row_bytes_o;
  logic [AW-1:0] row_src_o, row_dst_o, cur_src_o, cur_dst_o;
  logic [LEN_W-1:0] x_len_o;
  logic [IDW-1:0] rpt_id_o;
  logic [TW-1:0] rpt_len_o;

  logic b1_busy, b1_done, b1_part;
  logic [YW-1:0] b1_ridx, b1_ylen;
  logic [LEN_W:0] b1_rbytes;
  logic [AW-1:0] b1_rsrc, b1_rdst, b1_csrc, b1_cdst;
  logic [LEN_W-1:0] b1_xlen;
  logic [IDW-1:0] b1_rid;
  logic [TW-1:0] b1_rlen;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  strided_agen u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_id_i(load_id_i),
    .load_src_i(load_src_i), .load_dst_i(load_dst_i),
    .load_src_stride_i(load_src_stride_i), .load_dst_stride_i(load_dst_stride_i),
    .load_x_i(load_x_i), .load_y_i(load_y_i), .load_cyclic_i(load_cyclic_i),
    .beat_i(beat_i), .row_done_i(row_done_i), .abort_i(abort_i),
    .busy_o(busy_o), .row_idx_o(row_idx_o), .row_bytes_o(row_bytes_o),
    .row_src_o(row_src_o), .row_dst_o(row_dst_o), .cur_src_o(cur_src_o),
    .cur_dst_o(cur_dst_o), .x_len_o(x_len_o), .y_len_o(y_len_o),
    .done_o(done_o), .partial_o(partial_o), .rpt_id_o(rpt_id_o), .rpt_len_o(rpt_len_o));

  strided_agen #(.TWO_D(1'b0)) u_dut1d (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_id_i(load_id_i),
    .load_src_i(load_src_i), .load_dst_i(load_dst_i),
    .load_src_stride_i(load_src_stride_i), .load_dst_stride_i(load_dst_stride_i),
    .load_x_i(load_x_i), .load_y_i(load_y_i), .load_cyclic_i(load_cyclic_i),
    .beat_i(beat_i), .row_done_i(row_done_i), .abort_i(abort_i),
    .busy_o(b1_busy), .row_idx_o(b1_ridx), .row_bytes_o(b1_rbytes),
    .row_src_o(b1_rsrc), .row_dst_o(b1_rdst), .cur_src_o(b1_csrc),
    .cur_dst_o(b1_cdst), .x_len_o(b1_xlen), .y_len_o(b1_ylen),
    .done_o(b1_done), .partial_o(b1_part), .rpt_id_o(b1_rid), .rpt_len_o(b1_rlen));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic load(input int id, input int src, input int dst, input int ss,
                      input int ds, input int x, input int y, input bit cyc);
    load_i = 1; load_id_i = IDW'(id); load_src_i = AW'(src); load_dst_i = AW'(dst);
    load_src_stride_i = AW'(ss); load_dst_stride_i = AW'(ds);
    load_x_i = XIN_W'(x); load_y_i = YW'(y); load_cyclic_i = cyc;
    step();
    load_i = 0;
  endtask

  task automatic beats(input int n);
    for (int i = 0; i < n; i++) begin
      beat_i = 1; step();
    end
    beat_i = 0;
  endtask

  task automatic rowdone(input bit ab, input bit bt);
    row_done_i = 1; abort_i = ab; beat_i = bt;
    step();
    row_done_i = 0; abort_i = 0; beat_i = 0;
  endtask

  task automatic abort_now(input bit bt);
    abort_i = 1; beat_i = bt;
    step();
    abort_i = 0; beat_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int xs[4] = '{3, 7, 12, 60};
    int xv, ss, ds, sb, db, k, held;
    step(); step();
    rst_n = 1;
    step();
    chk("R10 busy", busy_o, 0);
    chk("R10 done", done_o, 0);
    chk("R10 partial", partial_o, 0);

    // R1/R2 probing
    load(1, 0, 0, 0, 0, 16'hFFFF, 9, 0);
    chk("R1 max", x_len_o, 255);
    chk("R1 bytes", row_bytes_o, 256);
    chk("R2 y 2d", y_len_o, 9);
    chk("R2 y 1d", b1_ylen, 0);
    abort_now(0);
    load(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 align", x_len_o, 3);
    abort_now(0);
    load(1, 0, 0, 0, 0, 5, 0, 0);
    chk("R1 round", x_len_o, 7);
    abort_now(0);

    // R3/R4/R5 sweep
    for (int xi = 0; xi < 4; xi++) begin
      for (int y = 0; y < 4; y++) begin
        xv = (xs[xi] | 3) + 1;
        ss = 64 + 4 * y; ds = 32 * (xi + 1);
        sb = 16'h1000 + 16 * xi; db = 16'h8000 + 8 * y;
        load(xi + y, sb, db, ss, ds, xs[xi], y, 0);
        chk("R5 busy", busy_o, 1);
        for (int r = 0; r <= y; r++) begin
          chk("R3 idx", row_idx_o, r);
          chk("R3 src", row_src_o, (sb + r * ss) & 16'hFFFF);
          chk("R3 dst", row_dst_o, (db + r * ds) & 16'hFFFF);
          chk("R1 rowbytes", row_bytes_o, xv);
          k = (r % 2) + 1;
          beats(k);
          chk("R4 cur src", cur_src_o, (sb + r * ss + k * BB) & 16'hFFFF);
          chk("R4 cur dst", cur_dst_o, (db + r * ds + k * BB) & 16'hFFFF);
          rowdone(0, 0);
          if (r < y) begin
            chk("R4 cur next", cur_src_o, (sb + (r + 1) * ss) & 16'hFFFF);
            chk("R5 no done", done_o, 0);
          end
        end
        chk("R5 done", done_o, 1);
        chk("R5 len", rpt_len_o, xv * (y + 1));
        chk("R5 id", rpt_id_o, (xi + y) & 15);
        chk("R5 idle", busy_o, 0);
        step();
        chk("R5 pulse", done_o, 0);
      end
    end

    // R7 abort mid-row with beat in abort cycle
    load(3, 16'h2000, 16'h3000, 32, 32, 15, 3, 0);
    rowdone(0, 0); rowdone(0, 0);
    beats(2);
    abort_now(1);
    chk("R7 partial", partial_o, 1);
    chk("R7 no done", done_o, 0);
    chk("R7 busy", busy_o, 0);
    chk("R7 len", rpt_len_o, 2 * 16 + 3 * 4);
    chk("R7 id", rpt_id_o, 3);

    // R7 abort with row_done on a middle row
    load(4, 16'h2000, 16'h3000, 32, 32, 7, 2, 0);
    beats(1);
    rowdone(1, 0);
    chk("R7 mid partial", partial_o, 1);
    chk("R7 mid len", rpt_len_o, 8);
    chk("R7 mid busy", busy_o, 0);

    // R8 abort together with last row_done
    load(6, 16'h2000, 16'h3000, 32, 32, 7, 1, 0);
    rowdone(0, 0);
    rowdone(1, 0);
    chk("R8 done", done_o, 1);
    chk("R8 no partial", partial_o, 0);
    chk("R8 len", rpt_len_o, 16);
    chk("R8 busy", busy_o, 0);

    // R6 cyclic restart
    load(7, 16'h4000, 16'h5000, 40, 24, 7, 1, 1);
    rowdone(0, 0);
    beats(1);
    rowdone(0, 0);
    chk("R6 done", done_o, 1);
    chk("R6 len", rpt_len_o, 16);
    chk("R6 busy", busy_o, 1);
    chk("R6 idx", row_idx_o, 0);
    chk("R6 src", row_src_o, 16'h4000);
    chk("R6 cur", cur_dst_o, 16'h5000);
    rowdone(0, 0);
    chk("R6 row1 src", row_src_o, 16'h4000 + 40);
    chk("R6 no done", done_o, 0);
    abort_now(1);
    chk("R7 cyclic partial", partial_o, 1);
    chk("R7 cyclic len", rpt_len_o, 8 + 4);
    // R7 in cyclic mode: abort coinciding with a middle-row completion
    load(7, 16'h4000, 16'h5000, 40, 24, 7, 1, 1);
    rowdone(1, 0);
    chk("R7 cyclic mid partial", partial_o, 1);
    chk("R7 cyclic mid len", rpt_len_o, 8);
    chk("R7 cyclic mid busy", busy_o, 0);

    // R9 load while busy ignored
    load(5, 16'h0100, 16'h0200, 16, 16, 3, 1, 0);
    load(9, 16'h0900, 16'h0A00, 16, 16, 3, 1, 0);
    chk("R9 src kept", row_src_o, 16'h0100);
    chk("R9 y kept", y_len_o, 1);
    rowdone(0, 0); rowdone(0, 0);
    chk("R9 id kept", rpt_id_o, 5);
    chk("R9 done", done_o, 1);

    // R9 idle stimulus ignored
    held = cur_src_o;
    beat_i = 1; row_done_i = 1; step();
    beat_i = 0; row_done_i = 0;
    abort_now(1);
    chk("R9 idle busy", busy_o, 0);
    chk("R9 idle partial", partial_o, 0);
    chk("R9 idle done", done_o, 0);
    chk("R9 idle cur", cur_src_o, held);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule